// File: doc/BRIEF.md
# Floating-Point 8-Bit Immediate Encoder

This block takes an IEEE single- or double-precision bit pattern and decides whether the value fits in a compact 8-bit floating-point immediate. The compact form has a sign bit, a 3-bit exponent and a 4-bit mantissa. If the value fits, the block produces that byte. If it does not, the block raises no flag and returns a zero byte. An instruction encoder can use it to choose between a short immediate form and a literal load.

The operand arrives as a 64-bit word with a precision select and a valid strobe. In single precision only the low 32 bits are used. The decision logic is combinational. One register stage sits in front of the outputs, so each result appears one clock after the strobe that carried the operand. The operand is not rounded: any fraction bit that would be lost causes a rejection.

Top module: `fp_imm8_encoder`

## Requirements
- R1: A synchronous active-high reset drives out_valid, out_ok and out_imm to zero on the next rising edge.
- R2: out_valid equals in_valid from the previous rising edge. The result for an operand appears one cycle after the operand is strobed.
- R3: With in_dbl low, the operand is bits 31:0: sign at 31, an 8-bit exponent at 30:23 with bias 127, and the fraction at 22:0. Bits 63:32 have no effect. With in_dbl high, the sign is at 63, an 11-bit exponent at 62:52 with bias 1023, and the fraction at 51:0.
- R4: A value is accepted only if its unbiased exponent (field minus bias) lies between -3 and +4 inclusive.
- R5: A value is accepted only if every fraction bit below the four most significant fraction bits is zero.
- R6: For an accepted value, out_imm bit 7 is the sign and bits 6:4 are (unbiased exponent + 7) mod 8. Bits 3:0 are the top four fraction bits. For example, 1.0 gives 0x70, 2.0 gives 0x00, 0.125 gives 0x40 and 31.0 gives 0x3F.
- R7: For a rejected value, out_ok is 0 and out_imm is 0x00.
- R8: Zero, infinity and NaN inputs of either precision are reported as rejected.
- R9: While in_valid is low, out_imm and out_ok keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| in_word | input | 64 | Floating-point bit pattern |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_ok | output | 1 | Value fits the 8-bit immediate |
| out_imm | output | 8 | Encoded immediate, zero when out_ok is low |

## Verification
Every decision reaches the ports after exactly one register. A wrong exponent offset, a wrong bias or a misplaced field therefore shows on the very next cycle. It appears either as a wrong bit pattern in out_imm[6:4] or as a wrong accept or reject verdict at the range edges -3, +4, -4 and +5. A tail-zero check that starts at the wrong bit shows up as a wrong verdict when a single low fraction bit is set. A precision select that leaks the upper word shows up as a changed result for an operand whose upper half is not zero. A capture enable that is wrong shows up as a drifting held result while in_valid is low.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
   localparam int SGL_EXP_W  = 8;
   localparam int SGL_FRAC_W = 23;
   localparam int DBL_EXP_W  = 11;
   localparam int DBL_FRAC_W = 52;
   localparam int IMM_MANT_W = 4;
   localparam int IMM_EXP_W  = 3;

   typedef enum logic {PREC_SINGLE = 1'b0, PREC_DOUBLE = 1'b1} prec_e;
endpackage

// File: rtl/fpimm_lane.sv
module fpimm_lane #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int MANT_W = 4,
   parameter int PEXP_W = 3,
   localparam int FP_W  = 1 + EXP_W + FRAC_W,
   localparam int IMM_W = 1 + PEXP_W + MANT_W
) (
   input  logic [FP_W-1:0]  fp,
   output logic             fits,
   output logic [IMM_W-1:0] imm
);
   localparam int BIAS     = 2**(EXP_W-1) - 1;
   localparam int E_LO     = -(2**(PEXP_W-1) - 1);
   localparam int E_HI     = 2**(PEXP_W-1);
   localparam int SPAN     = E_HI - E_LO;
   localparam int PACK_ADD = 2**PEXP_W - 1 + E_LO;
   localparam int TAIL_W   = FRAC_W - MANT_W;
   localparam logic [EXP_W-1:0] BASE  = EXP_W'(BIAS + E_LO);
   localparam logic [EXP_W-1:0] SPANV = EXP_W'(SPAN);
   localparam logic [EXP_W-1:0] ADDV  = EXP_W'(PACK_ADD);

   generate
      if (FRAC_W <= MANT_W) begin : g_bad_frac
         $error("fpimm_lane: FRAC_W must exceed MANT_W");
      end
      if (EXP_W <= PEXP_W) begin : g_bad_exp
         $error("fpimm_lane: EXP_W must exceed PEXP_W");
      end
   endgenerate

   logic              sign;
   logic [EXP_W-1:0]  expf;
   logic [FRAC_W-1:0] frac;
   logic [EXP_W-1:0]  off;
   logic [EXP_W-1:0]  pex_sum;
   logic              in_range;
   logic              tail_zero;

   always_comb begin
      sign      = fp[FP_W-1];
      expf      = fp[FRAC_W +: EXP_W];
      frac      = fp[FRAC_W-1:0];
      off       = expf - BASE;
      in_range  = (expf >= BASE) && (off <= SPANV);
      tail_zero = ~|frac[TAIL_W-1:0];
      pex_sum   = off + ADDV;
      fits      = in_range && tail_zero;
      imm       = {sign, pex_sum[PEXP_W-1:0], frac[FRAC_W-1 -: MANT_W]};
   end
endmodule

// File: rtl/fpimm_stage.sv
module fpimm_stage #(
   parameter int IMM_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             fits,
   input  logic [IMM_W-1:0] imm,
   output logic             out_valid,
   output logic             out_ok,
   output logic [IMM_W-1:0] out_imm
);
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_ok    <= 1'b0;
         out_imm   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_ok  <= fits;
            out_imm <= fits ? imm : '0;
         end
      end
   end

   assert_reject_zero_R7: assert property (@(posedge clk) disable iff (rst)
      !out_ok |-> (out_imm == '0));

   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_imm) && $stable(out_ok)));
endmodule

// File: rtl/fp_imm8_encoder.sv
module fp_imm8_encoder
   import fpimm_pkg::*;
#(
   parameter int WORD_W = 64,
   localparam int IMM_W = 1 + IMM_EXP_W + IMM_MANT_W,
   localparam int SGL_W = 1 + SGL_EXP_W + SGL_FRAC_W,
   localparam int DBL_W = 1 + DBL_EXP_W + DBL_FRAC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_dbl,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   output logic              out_ok,
   output logic [IMM_W-1:0]  out_imm
);
   generate
      if (DBL_W > WORD_W) begin : g_bad_word
         $error("fp_imm8_encoder: WORD_W too narrow for double precision");
      end
   endgenerate

   logic             fits_s, fits_d, fits_sel;
   logic [IMM_W-1:0] imm_s, imm_d, imm_sel;
   prec_e            prec;

   fpimm_lane #(
      .EXP_W (SGL_EXP_W), .FRAC_W(SGL_FRAC_W),
      .MANT_W(IMM_MANT_W), .PEXP_W(IMM_EXP_W)
   ) u_lane_s (
      .fp  (in_word[SGL_W-1:0]),
      .fits(fits_s),
      .imm (imm_s)
   );

   fpimm_lane #(
      .EXP_W (DBL_EXP_W), .FRAC_W(DBL_FRAC_W),
      .MANT_W(IMM_MANT_W), .PEXP_W(IMM_EXP_W)
   ) u_lane_d (
      .fp  (in_word[DBL_W-1:0]),
      .fits(fits_d),
      .imm (imm_d)
   );

   always_comb begin
      prec     = prec_e'(in_dbl);
      fits_sel = (prec == PREC_DOUBLE) ? fits_d : fits_s;
      imm_sel  = (prec == PREC_DOUBLE) ? imm_d  : imm_s;
   end

   fpimm_stage #(.IMM_W(IMM_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .fits     (fits_sel),
      .imm      (imm_sel),
      .out_valid(out_valid),
      .out_ok   (out_ok),
      .out_imm  (out_imm)
   );

   // Single-precision exponent above +4 must be rejected
   assert_sgl_exp_high_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_dbl && (in_word[30:23] > 8'd131)) |=> !out_ok);

   // Double-precision exponent below -3 must be rejected
   assert_dbl_exp_low_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_dbl && (in_word[62:52] < 11'd1020)) |=> !out_ok);

   assert_sgl_tail_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_dbl && (in_word[18:0] != '0)) |=> !out_ok);

   assert_dbl_tail_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_dbl && (in_word[47:0] != '0)) |=> !out_ok);
endmodule

// File: tb/tb_fp_imm8_encoder.sv
module tb_fp_imm8_encoder;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_dbl;
   logic [63:0] in_word;
   logic        out_valid;
   logic        out_ok;
   logic [7:0]  out_imm;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fp_imm8_encoder dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_dbl(in_dbl),
      .in_word(in_word), .out_valid(out_valid), .out_ok(out_ok),
      .out_imm(out_imm)
   );

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic dbl,
                        input logic [63:0] word, input logic ok_e,
                        input logic [7:0] imm_e);
      @(negedge clk);
      in_valid = 1'b1; in_dbl = dbl; in_word = word;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, 64'(out_valid), 64'd1);
      check({req, " ok"},    64'(out_ok),    64'(ok_e));
      check({req, " imm"},   64'(out_imm),   64'(imm_e));
   endtask

   task automatic t_reset;
      rst = 1'b1; in_valid = 1'b0; in_dbl = 1'b0; in_word = '0;
      repeat (3) @(negedge clk);
      check("R1 valid", 64'(out_valid), 64'd0);
      check("R1 ok",    64'(out_ok),    64'd0);
      check("R1 imm",   64'(out_imm),   64'd0);
      rst = 1'b0;
   endtask

   task automatic t_single_pack;
      apply("R6 s 1.0",   1'b0, 64'h3F80_0000, 1'b1, 8'h70);
      apply("R6 s 2.0",   1'b0, 64'h4000_0000, 1'b1, 8'h00);
      apply("R6 s 31.0",  1'b0, 64'h41F8_0000, 1'b1, 8'h3F);
      apply("R6 s -1.5",  1'b0, 64'hBFC0_0000, 1'b1, 8'hF8);
   endtask

   task automatic t_single_range;
      apply("R4 s 0.125 lo edge", 1'b0, 64'h3E00_0000, 1'b1, 8'h40);
      apply("R4 s 16.0 hi edge",  1'b0, 64'h4180_0000, 1'b1, 8'h30);
      apply("R4 s 0.0625 below",  1'b0, 64'h3D80_0000, 1'b0, 8'h00);
      apply("R4 s 32.0 above",    1'b0, 64'h4200_0000, 1'b0, 8'h00);
   endtask

   task automatic t_tail;
      apply("R5 s bit18",  1'b0, 64'h3F84_0000, 1'b0, 8'h00);
      apply("R5 s bit0",   1'b0, 64'h3F80_0001, 1'b0, 8'h00);
      apply("R5 d bit0",   1'b1, 64'h3FF0_0000_0000_0001, 1'b0, 8'h00);
      apply("R5 d bit47",  1'b1, 64'h3FF0_8000_0000_0000, 1'b0, 8'h00);
   endtask

   task automatic t_double;
      apply("R3 d 1.0",     1'b1, 64'h3FF0_0000_0000_0000, 1'b1, 8'h70);
      apply("R3 d 0.25",    1'b1, 64'h3FD0_0000_0000_0000, 1'b1, 8'h50);
      apply("R3 d -0.1875", 1'b1, 64'hBFC8_0000_0000_0000, 1'b1, 8'hC8);
      apply("R4 d 32.0",    1'b1, 64'h4040_0000_0000_0000, 1'b0, 8'h00);
   endtask

   task automatic t_upper_ignored;
      apply("R3 s upper junk",   1'b0, 64'hDEAD_BEEF_3F80_0000, 1'b1, 8'h70);
      apply("R3 d low as single", 1'b1, 64'h0000_0000_3F80_0000, 1'b0, 8'h00);
   endtask

   task automatic t_special;
      apply("R8 s zero", 1'b0, 64'h0000_0000, 1'b0, 8'h00);
      apply("R8 s inf",  1'b0, 64'h7F80_0000, 1'b0, 8'h00);
      apply("R8 s nan",  1'b0, 64'h7FC0_0000, 1'b0, 8'h00);
      apply("R8 d inf",  1'b1, 64'h7FF0_0000_0000_0000, 1'b0, 8'h00);
      apply("R8 d -zero", 1'b1, 64'h8000_0000_0000_0000, 1'b0, 8'h00);
   endtask

   task automatic t_reject_after_accept;
      apply("R7 accept first", 1'b0, 64'h3F80_0000, 1'b1, 8'h70);
      apply("R7 reject zeroes", 1'b0, 64'h4200_0000, 1'b0, 8'h00);
   endtask

   task automatic t_hold;
      apply("R9 load", 1'b0, 64'h41F8_0000, 1'b1, 8'h3F);
      in_word = 64'h4200_0000; in_dbl = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 hold imm",  64'(out_imm),   64'h3F);
      check("R9 hold ok",   64'(out_ok),    64'd1);
      check("R2 idle valid", 64'(out_valid), 64'd0);
   endtask

   task automatic t_latency;
      @(negedge clk);
      in_valid = 1'b1; in_dbl = 1'b0; in_word = 64'h3F80_0000;
      @(posedge clk); #1;
      check("R2 same-cycle valid", 64'(out_valid), 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R2 drop valid", 64'(out_valid), 64'd0);
   endtask

   task automatic t_midrun_reset;
      apply("R1 pre", 1'b0, 64'h3F80_0000, 1'b1, 8'h70);
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      check("R1 mid ok",  64'(out_ok),  64'd0);
      check("R1 mid imm", 64'(out_imm), 64'd0);
      rst = 1'b0;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      t_reset();
      t_single_pack();
      t_single_range();
      t_tail();
      t_double();
      t_upper_ignored();
      t_special();
      t_reject_after_accept();
      t_hold();
      t_latency();
      t_midrun_reset();
      finished = 1'b1;
      summary();
   end

   initial begin
      #400000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end
endmodule